// File: doc/BRIEF.md
# Two-Entry Receive Message Queue

This block sits between a packet link layer and a host register interface. It holds at most two received messages. The link presents a header with a frame-type code and a payload length, and then streams the payload bytes. The block decides at the header whether to accept the packet and answers with a one-cycle accept or refuse pulse. An accepted payload is stored in one of two slot banks. A message enters the queue when its last byte arrives.

The host controls which frame types are accepted through a 7-bit enable register. It reads the head message through a byte-indexed read port. It consumes the head message by clearing the receive-status alert, which promotes the second entry if one is queued. A received hard-reset packet flushes the queue and closes the enables. A cable-reset packet flushes the queue and is then stored like any other message. Protocol misuse on the read port sets a sticky interface-fault flag.

Top module: `rx_msg_queue`

## Requirements
- R1: Frame codes are SOP=0, SOP'=1, SOP''=2, debug'=3, debug''=4, hard reset=5, cable reset=6. A header is accepted only if bit `hdr_type` of `det_en` is set. Code 7 is always refused. `hdr_ack` or `hdr_nak` pulses in the cycle after `hdr_valid`, and a refused packet stores nothing.
- R2: On an empty queue, the first message may carry up to 31 payload bytes, or up to 265 when `long_cap` is 1. A message behind a queued one may carry at most 31 bytes. A header is refused when two messages are held, and when a payload is still being received (reset types excepted).
- R3: When a message completes while another stays queued, alert bit 1 (overflow) is set.
- R4: Every completed message sets alert bit 0 (receive status). A message longer than 133 bytes also sets alert bit 2 (long message begun).
- R5: A read returns data in the cycle after `rd_en`. Index 0 returns (length+1) mod 256 of the head message. Index 1 returns its frame code. Any index of 2 or more returns the next payload byte in order.
- R6: With no message held, indices 0 and 1 read 0. A payload read with no message held, or one beyond the stored length, returns 0 and sets `fault_iface`. `fault_iface` stays set until `fault_clr`.
- R7: An accepted hard-reset header empties the queue, clears `det_en` to 0 and sets alert bit 3. Payload bytes that follow it are not stored.
- R8: An accepted cable-reset header first empties the queue. It is then stored as a normal message under the empty-queue limits, without raising overflow.
- R9: A pulse on `rewind` returns the payload read position of the head message to its first byte.
- R10: Writing 1 to `alert_clr[0]` consumes the head message. Any second message becomes the head, its read position at the start. Alert bit 0 stays set while a message remains. Alert bit 1 clears. Writing 1 to `alert_clr[3:1]` clears those bits.
- R11: Writing 0 to the enable register empties the queue.
- R12: After reset, `det_en`, `alert`, `fault_iface`, `hdr_ack`, `hdr_nak` and `rd_data` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_we | input | 1 | Write strobe for the frame-type enable register |
| det_wdata | input | 7 | New enable value, one bit per frame code |
| det_en | output | 7 | Current enable register |
| long_cap | input | 1 | Allows first messages of up to 265 bytes |
| hdr_valid | input | 1 | Header strobe from the link layer |
| hdr_type | input | 3 | Frame code of the header |
| hdr_len | input | 9 | Payload byte count of the header |
| hdr_ack | output | 1 | Header accepted (one-cycle pulse) |
| hdr_nak | output | 1 | Header refused, reported to the sender as a failed send |
| byte_valid | input | 1 | Payload byte strobe |
| byte_data | input | 8 | Payload byte |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 9 | Byte index within the read sequence |
| rd_data | output | 8 | Read result, held until the next read |
| rewind | input | 1 | Restart the payload read position |
| alert_clr | input | 4 | Write-one-to-clear alert bits |
| alert | output | 4 | Alert bits: 0 status, 1 overflow, 2 long begun, 3 hard reset |
| fault_clr | input | 1 | Clears the interface fault |
| fault_iface | output | 1 | Sticky interface-fault flag |

## Verification
A wrong queue count or head pointer shows in the first index-0 or index-1 read after the error. The read returns a stale length or frame code, or zero where a message should be. A missed promotion shows in the first payload read after receive-status is cleared. Admission errors show one cycle after the header on `hdr_ack`/`hdr_nak`. Alert errors show one cycle after the final payload byte.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int NUM_FT = 7;

  typedef enum logic [2:0] {
    FT_SOP  = 3'd0,
    FT_SOP1 = 3'd1,
    FT_SOP2 = 3'd2,
    FT_DBG1 = 3'd3,
    FT_DBG2 = 3'd4,
    FT_HRST = 3'd5,
    FT_CRST = 3'd6
  } frame_t;

  localparam int AL_RXS  = 0;
  localparam int AL_OVF  = 1;
  localparam int AL_BEG  = 2;
  localparam int AL_HRST = 3;
  localparam int AL_W    = 4;
endpackage

// File: rtl/rxq_admit.sv
module rxq_admit
  import rxq_pkg::*;
#(
  parameter int LEN_W     = 9,
  parameter int SHORT_MAX = 31,
  parameter int LONG_MAX  = 265
) (
  input  logic              hdr_valid,
  input  logic [2:0]        hdr_type,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              long_cap,
  input  logic [NUM_FT-1:0] det,
  input  logic [1:0]        q_cnt,
  input  logic              filling,
  output logic              take,
  output logic              refuse,
  output logic              is_hrst,
  output logic              is_crst
);
  logic [7:0]       det_ext;
  logic [2:0]       occ;
  logic [LEN_W-1:0] limit;
  logic             enabled;
  logic             fits;

  always_comb begin
    det_ext = 8'(det);
    enabled = det_ext[hdr_type];
    is_hrst = (hdr_type == FT_HRST);
    is_crst = (hdr_type == FT_CRST);
    // a cable reset flushes first, so it sees an empty queue
    occ     = is_crst ? 3'd0 : ({1'b0, q_cnt} + {2'b00, filling});
    limit   = (occ == 3'd0 && long_cap) ? LEN_W'(LONG_MAX) : LEN_W'(SHORT_MAX);
    fits    = is_hrst || ((!filling || is_crst) && occ < 3'd2 && hdr_len <= limit);
    take    = hdr_valid && enabled && fits;
    refuse  = hdr_valid && !take;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 265,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wslot,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          rslot,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wslot == 1'(b))) mem[waddr] <= wdata;
    end
    assign bank_rd[b] = mem[raddr];
  end

  assign rdata = bank_rd[rslot];
endmodule

// File: rtl/rx_msg_queue.sv
module rx_msg_queue
  import rxq_pkg::*;
#(
  parameter int SHORT_MAX    = 31,
  parameter int LONG_MAX     = 265,
  parameter int BEGIN_THRESH = 133,
  localparam int LEN_W       = $clog2(LONG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_we,
  input  logic [NUM_FT-1:0] det_wdata,
  output logic [NUM_FT-1:0] det_en,
  input  logic              long_cap,
  input  logic              hdr_valid,
  input  logic [2:0]        hdr_type,
  input  logic [LEN_W-1:0]  hdr_len,
  output logic              hdr_ack,
  output logic              hdr_nak,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              rd_en,
  input  logic [LEN_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  input  logic              rewind,
  input  logic [AL_W-1:0]   alert_clr,
  output logic [AL_W-1:0]   alert,
  input  logic              fault_clr,
  output logic              fault_iface
);
  logic [NUM_FT-1:0]       det_q, det_d;
  logic [1:0]              q_cnt_q, q_cnt_d, remain, base;
  logic                    fill_q, fill_d, head_q, head_d, wslot_q, wslot_d, wslot_n;
  logic [LEN_W-1:0]        wptr_q, wptr_d, rptr_q, rptr_d, done_len;
  logic [1:0][LEN_W-1:0]   len_q, len_d;
  logic [1:0][2:0]         type_q, type_d;
  logic [AL_W-1:0]         alert_q, alert_d;
  logic                    fault_q, fault_d, ack_q, nak_q;
  logic [7:0]              rd_data_q, rd_data_d, mem_rdata;
  logic                    take, refuse, is_hrst, is_crst;
  logic                    pop, flush, mem_we, done, present;

  rxq_admit #(.LEN_W(LEN_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)) u_admit (
    .hdr_valid(hdr_valid), .hdr_type(hdr_type), .hdr_len(hdr_len), .long_cap(long_cap),
    .det(det_q), .q_cnt(q_cnt_q), .filling(fill_q),
    .take(take), .refuse(refuse), .is_hrst(is_hrst), .is_crst(is_crst)
  );

  rxq_store #(.DEPTH(LONG_MAX), .AW(LEN_W)) u_store (
    .clk(clk), .we(mem_we), .wslot(wslot_q), .waddr(wptr_q), .wdata(byte_data),
    .rslot(head_q), .raddr(rptr_q), .rdata(mem_rdata)
  );

  always_comb begin
    det_d = det_q;  fill_d = fill_q;  head_d = head_q;  wslot_d = wslot_q;
    wptr_d = wptr_q;  rptr_d = rptr_q;  len_d = len_q;  type_d = type_q;
    alert_d = alert_q;  fault_d = fault_q;  rd_data_d = rd_data_q;
    mem_we = 1'b0;  done = 1'b0;  done_len = '0;  base = '0;  wslot_n = head_q;
    present = (q_cnt_q != 2'd0);
    pop     = alert_clr[AL_RXS] && present;
    remain  = q_cnt_q - {1'b0, pop};
    flush   = (det_we && det_wdata == '0) || (take && (is_hrst || is_crst));

    if (fault_clr) fault_d = 1'b0;
    for (int i = 1; i < AL_W; i++) if (alert_clr[i]) alert_d[i] = 1'b0;
    if (alert_clr[AL_RXS]) begin
      alert_d[AL_RXS] = (remain != 2'd0);
      alert_d[AL_OVF] = 1'b0;
    end

    // read port on the current head
    if (rd_en) begin
      rd_data_d = '0;
      if (rd_idx == '0) begin
        if (present) rd_data_d = 8'({1'b0, len_q[head_q]} + 1'b1);
      end else if (rd_idx == LEN_W'(1)) begin
        if (present) rd_data_d = 8'(type_q[head_q]);
      end else if (present && rptr_q < len_q[head_q]) begin
        rd_data_d = mem_rdata;
        rptr_d    = rptr_q + 1'b1;
      end else begin
        fault_d = 1'b1;
      end
    end
    if (rewind) rptr_d = '0;
    if (pop) begin
      head_d = ~head_q;
      rptr_d = '0;
    end

    // payload fill
    if (fill_q && byte_valid && !take && !flush) begin
      mem_we = 1'b1;
      wptr_d = wptr_q + 1'b1;
      if (wptr_q == len_q[wslot_q] - 1'b1) begin
        done     = 1'b1;
        fill_d   = 1'b0;
        done_len = len_q[wslot_q];
      end
    end

    if (det_we) det_d = det_wdata;
    if (flush) begin
      fill_d = 1'b0;
      rptr_d = '0;
    end

    if (take && is_hrst) begin
      det_d            = '0;
      alert_d[AL_HRST] = 1'b1;
    end else if (take) begin
      base          = is_crst ? 2'd0 : remain;
      wslot_n       = head_d ^ base[0];
      wslot_d       = wslot_n;
      wptr_d        = '0;
      len_d[wslot_n]  = hdr_len;
      type_d[wslot_n] = hdr_type;
      if (hdr_len == '0) done = 1'b1;
      else               fill_d = 1'b1;
    end

    q_cnt_d = (flush ? 2'd0 : remain) + {1'b0, done};
    if (done) begin
      alert_d[AL_RXS] = 1'b1;
      if (!flush && remain == 2'd1) alert_d[AL_OVF] = 1'b1;
      if (done_len > LEN_W'(BEGIN_THRESH)) alert_d[AL_BEG] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= '0;  q_cnt_q <= '0;  fill_q <= 1'b0;  head_q <= 1'b0;  wslot_q <= 1'b0;
      wptr_q <= '0;  rptr_q <= '0;  len_q <= '0;  type_q <= '0;  alert_q <= '0;
      fault_q <= 1'b0;  ack_q <= 1'b0;  nak_q <= 1'b0;  rd_data_q <= '0;
    end else begin
      det_q <= det_d;  q_cnt_q <= q_cnt_d;  fill_q <= fill_d;  head_q <= head_d;
      wslot_q <= wslot_d;  wptr_q <= wptr_d;  rptr_q <= rptr_d;  len_q <= len_d;
      type_q <= type_d;  alert_q <= alert_d;  fault_q <= fault_d;
      ack_q <= take;  nak_q <= refuse;  rd_data_q <= rd_data_d;
    end
  end

  assign det_en      = det_q;
  assign hdr_ack     = ack_q;
  assign hdr_nak     = nak_q;
  assign rd_data     = rd_data_q;
  assign alert       = alert_q;
  assign fault_iface = fault_q;

  assert_code7_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_type == 3'd7) |=> (hdr_nak && !hdr_ack));
  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt_q <= 2'd2);
  assert_fill_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> (wptr_q < len_q[wslot_q]));
  assert_ovf_two_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_q[AL_OVF]) |-> (q_cnt_q == 2'd2));
  assert_empty_read_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx > LEN_W'(1) && q_cnt_q == 2'd0) |=> fault_iface);
  assert_hrst_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_hrst) |=> (det_q == '0 && q_cnt_q == 2'd0 && alert_q[AL_HRST]));
  assert_status_while_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt_q != 2'd0) |-> alert_q[AL_RXS]);
endmodule

// File: tb/rx_msg_queue_bench.sv
`timescale 1ns/1ps
module rx_msg_queue_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       det_we = 1'b0;
  logic [6:0] det_wdata = '0;
  logic [6:0] det_en;
  logic       long_cap = 1'b0;
  logic       hdr_valid = 1'b0;
  logic [2:0] hdr_type = '0;
  logic [8:0] hdr_len = '0;
  logic       hdr_ack, hdr_nak;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       rd_en = 1'b0;
  logic [8:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       rewind = 1'b0;
  logic [3:0] alert_clr = '0;
  logic [3:0] alert;
  logic       fault_clr = 1'b0;
  logic       fault_iface;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rx_msg_queue u_rx_msg_queue (
    .clk(clk), .rst_n(rst_n), .det_we(det_we), .det_wdata(det_wdata), .det_en(det_en),
    .long_cap(long_cap), .hdr_valid(hdr_valid), .hdr_type(hdr_type), .hdr_len(hdr_len),
    .hdr_ack(hdr_ack), .hdr_nak(hdr_nak), .byte_valid(byte_valid), .byte_data(byte_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rewind(rewind),
    .alert_clr(alert_clr), .alert(alert), .fault_clr(fault_clr), .fault_iface(fault_iface)
  );

  // {type[20:18], len[17:9], long_cap[8], enables[7:1], expect_accept[0]}
  localparam logic [20:0] VEC [8] = '{
    {3'd0, 9'd31,  1'b0, 7'h7f, 1'b1},
    {3'd0, 9'd32,  1'b0, 7'h7f, 1'b0},
    {3'd0, 9'd265, 1'b1, 7'h7f, 1'b1},
    {3'd0, 9'd266, 1'b1, 7'h7f, 1'b0},
    {3'd1, 9'd4,   1'b0, 7'h01, 1'b0},
    {3'd3, 9'd4,   1'b0, 7'h08, 1'b1},
    {3'd7, 9'd4,   1'b0, 7'h7f, 1'b0},
    {3'd2, 9'd0,   1'b0, 7'h04, 1'b1}
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_det(input logic [6:0] v);
    det_we = 1'b1; det_wdata = v; tick(); det_we = 1'b0;
  endtask

  task automatic hdr(input logic [2:0] t, input int n);
    hdr_valid = 1'b1; hdr_type = t; hdr_len = 9'(n); tick(); hdr_valid = 1'b0;
  endtask

  task automatic send_bytes(input int n, input int first);
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = 8'(first + i); tick();
    end
    byte_valid = 1'b0;
  endtask

  task automatic rd(input int idx);
    rd_en = 1'b1; rd_idx = 9'(idx); tick(); rd_en = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m);
    alert_clr = m; tick(); alert_clr = '0;
  endtask

  task automatic fclr();
    fault_clr = 1'b1; tick(); fault_clr = 1'b0;
  endtask

  initial begin
    #(4 * 50000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R12 det_en", int'(det_en), 0);
    chk("R12 alert", int'(alert), 0);
    chk("R12 fault", int'(fault_iface), 0);
    chk("R12 ack/nak", int'({hdr_ack, hdr_nak}), 0);
    chk("R12 rd_data", int'(rd_data), 0);

    // admission table (R1 enables/codes, R2 length limits)
    for (int r = 0; r < 8; r++) begin
      set_det(7'h00);
      set_det(VEC[r][7:1]);
      long_cap = VEC[r][8];
      hdr(VEC[r][20:18], int'(VEC[r][17:9]));
      chk($sformatf("R1/R2 row %0d ack", r), int'(hdr_ack), int'(VEC[r][0]));
      chk($sformatf("R1/R2 row %0d nak", r), int'(hdr_nak), int'(!VEC[r][0]));
    end
    set_det(7'h00);
    long_cap = 1'b0;
    clr(4'hF);
    fclr();

    // R6: empty reads
    set_det(7'h7f);
    rd(0); chk("R6 empty idx0", int'(rd_data), 0);
    rd(1); chk("R6 empty idx1", int'(rd_data), 0);
    chk("R6 no fault yet", int'(fault_iface), 0);
    rd(2); chk("R6 empty payload fault", int'(fault_iface), 1);
    fclr(); chk("R6 fault cleared", int'(fault_iface), 0);

    // R5, R9: readout order and rewind
    hdr(3'd0, 3); chk("R5 accept", int'(hdr_ack), 1);
    send_bytes(3, 8'h11);
    chk("R4 status only", int'(alert), 1);
    rd(0); chk("R5 idx0 len+1", int'(rd_data), 4);
    rd(1); chk("R5 idx1 type", int'(rd_data), 0);
    rd(2); chk("R5 payload0", int'(rd_data), 8'h11);
    rd(2); chk("R5 payload1", int'(rd_data), 8'h12);
    rewind = 1'b1; tick(); rewind = 1'b0;
    rd(2); chk("R9 rewound", int'(rd_data), 8'h11);
    rd(2); rd(2); chk("R5 payload2", int'(rd_data), 8'h13);
    chk("R6 no fault in range", int'(fault_iface), 0);
    rd(2); chk("R6 past end fault", int'(fault_iface), 1);
    chk("R6 past end data", int'(rd_data), 0);
    fclr();

    // R2, R3: second entry
    hdr(3'd1, 32); chk("R2 second too long", int'(hdr_nak), 1);
    hdr(3'd1, 2); chk("R2 second fits", int'(hdr_ack), 1);
    send_bytes(2, 8'h44);
    chk("R3 overflow set", int'(alert[1]), 1);
    hdr(3'd0, 1); chk("R2 third refused", int'(hdr_nak), 1);

    // R10: consume and promote
    clr(4'b0001);
    chk("R10 status kept", int'(alert[0]), 1);
    chk("R10 overflow cleared", int'(alert[1]), 0);
    rd(0); chk("R10 promoted len", int'(rd_data), 3);
    rd(1); chk("R10 promoted type", int'(rd_data), 1);
    rd(2); chk("R10 promoted payload", int'(rd_data), 8'h44);
    clr(4'b0001); chk("R10 status cleared", int'(alert[0]), 0);

    // R4: long-message begin threshold
    long_cap = 1'b1;
    hdr(3'd0, 133); chk("R2 long first", int'(hdr_ack), 1);
    send_bytes(133, 0);
    chk("R4 133 no begin", int'(alert[2]), 0);
    clr(4'b0001);
    hdr(3'd0, 134); send_bytes(134, 0);
    chk("R4 134 begin", int'(alert[2]), 1);
    chk("R4 134 status", int'(alert[0]), 1);
    rd(0); chk("R5 long len+1", int'(rd_data), 135);
    clr(4'b0101);
    long_cap = 1'b0;

    // R7: hard reset
    set_det(7'h21);
    hdr(3'd0, 1); send_bytes(1, 8'h77);
    hdr(3'd5, 0); chk("R7 accepted", int'(hdr_ack), 1);
    chk("R7 enables cleared", int'(det_en), 0);
    chk("R7 alert bit", int'(alert[3]), 1);
    send_bytes(1, 8'h99);
    rd(0); chk("R7 queue flushed", int'(rd_data), 0);
    clr(4'b1001);

    // R8: cable reset
    set_det(7'h41);
    hdr(3'd0, 1); send_bytes(1, 8'h5A);
    hdr(3'd6, 2); chk("R8 accepted", int'(hdr_ack), 1);
    send_bytes(2, 8'h60);
    chk("R8 no overflow", int'(alert[1]), 0);
    rd(0); chk("R8 len", int'(rd_data), 3);
    rd(1); chk("R8 type", int'(rd_data), 6);
    rd(2); chk("R8 payload", int'(rd_data), 8'h60);
    clr(4'b0001); chk("R8 single entry", int'(alert[0]), 0);

    // R11: disable flushes
    set_det(7'h01);
    hdr(3'd0, 1); send_bytes(1, 8'h33);
    set_det(7'h00);
    rd(0); chk("R11 flushed", int'(rd_data), 0);
    clr(4'b0001);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule